// File: doc/BRIEF.md
# Write-Once Windowed Watchdog Timer

This block supervises software by counting down on a slow, prescaled tick and requesting a reset when software fails to restart it in time. A slow input clock is divided by a fixed prescale ratio into a counting tick. Each tick decrements a 12-bit counter. When a tick arrives while the counter already holds zero, the block records an underflow and reloads the counter. If resets are enabled, it also drives one of two reset request outputs for a fixed number of clock cycles.

Software configures the block with one write to a mode word, and the mode word then locks until the next reset. Software restarts the counter with a keyed control write. A restart is accepted only while the counter has fallen to or below a programmed window limit. A restart that comes too early is refused: it raises a sticky window error and, when resets are enabled, also requests a reset. A debug-halt option freezes the countdown while an external debug signal is high. A disable option stops the block completely.

A top-level state machine has three states. `WD_ACTIVE` counts. It moves to `WD_FROZEN` when debug halt is enabled and the debug input is high, and back again when either condition drops. From either state it moves to `WD_OFF` once the disable option is programmed, and `WD_OFF` is left only by reset. A pulse state machine has two states. `PL_IDLE` moves to `PL_DRIVE` on a reset event. `PL_DRIVE` holds for the pulse length, and a new event restarts the pulse. It then returns to `PL_IDLE`.

Top module: `wdog_lockwin`

## Requirements
- R1: After reset the mode word reads 0x0FFF1FFF (reload 0xFFF, window 0xFFF, reset enable set), the counter reads 0xFFF, the lock reads 0, the status reads 0, and both reset outputs are low.
- R2: Only the first write to the mode word (write address 1) after reset takes effect. It sets the lock (read address 3, bit 0), and every later mode write leaves the mode readback (read address 0) unchanged. Mode fields: reload [11:0], reset enable [12], processor-only [13], disable [14], debug-halt enable [15], window [27:16], and bits [31:28] read as zero.
- R3: The first mode write, and every accepted restart, load the counter with the reload value and clear the prescaler. The counter then falls by one every PRESCALE clocks and never exceeds the reload value. The counter is read at address 2, bits [11:0].
- R4: A write to address 0 restarts the counter only when bits [31:24] equal 0xA5 and bit 0 is 1. Any other key, or a clear bit 0, changes nothing.
- R5: A keyed restart while the counter is above the window field is refused. The counter is not reloaded, the window error flag is set (status bit 1, and the window error output), and a reset pulse starts if reset enable is set.
- R6: A tick that arrives while the counter is zero sets the underflow flag (status bit 0, and the underflow output) and reloads the counter. Reading the status at address 1 returns both flags and clears them.
- R7: A reset event with reset enable set drives the system reset output high for exactly 4 clocks when processor-only is 0, or the processor reset output when it is 1. The two outputs are never high together, and neither goes high when reset enable is 0.
- R8: With the disable option set, the counter holds its value, no reset output goes high, and keyed restarts neither reload the counter nor raise a window error.
- R9: With debug-halt enabled, the counter and prescaler freeze while the debug input is high. With debug-halt clear, the debug input has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Slow clock that drives all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| dbg_halt_i | input | 1 | Debug halt request from the processor |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 1 | Write target: 0 control, 1 mode |
| wr_data_i | input | 32 | Write data |
| rd_en_i | input | 1 | Register read strobe; data appears one clock later |
| rd_addr_i | input | 2 | Read target: 0 mode, 1 status, 2 counter, 3 lock |
| rd_data_o | output | 32 | Registered read data |
| sys_rst_req_o | output | 1 | System reset request pulse |
| cpu_rst_req_o | output | 1 | Processor-only reset request pulse |
| uf_flag_o | output | 1 | Sticky underflow flag |
| win_err_o | output | 1 | Sticky window error flag |

## Verification
The hardest case to reach is a keyed restart that lands at a precise counter position, just above or just at the window limit. The limit can only be observed through a refused or accepted reload. The bench therefore counts clocks from the moment the mode write clears the prescaler. It places the restart at an edge where the counter value is known, first too early and then inside the window, and confirms the outcome through the counter readback and the error flag. Underflow pulses are located in the same way, from the clock count of the last load. This lets the bench check the pulse's first and last high cycles exactly.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Counter and field width of the countdown
    localparam int CNT_W = 12;
    // Key byte that unlocks a restart write
    localparam logic [7:0] RESTART_KEY = 8'hA5;

    // Mode word layout, most significant field first
    typedef struct packed {
        logic [31-(2*CNT_W+4):0] rsvd;
        logic [CNT_W-1:0]        window;
        logic                    halt_dbg;
        logic                    off;
        logic                    cpu_only;
        logic                    rst_en;
        logic [CNT_W-1:0]        reload;
    } wdog_mode_t;

    localparam wdog_mode_t MODE_DEFAULT = '{
        rsvd:     '0,
        window:   '1,
        halt_dbg: 1'b0,
        off:      1'b0,
        cpu_only: 1'b0,
        rst_en:   1'b1,
        reload:   '1
    };

    // Top-level supervision states
    typedef enum logic [1:0] {
        WD_ACTIVE = 2'd0,
        WD_FROZEN = 2'd1,
        WD_OFF    = 2'd2
    } wd_state_e;

    // Reset pulse states
    typedef enum logic {
        PL_IDLE  = 1'b0,
        PL_DRIVE = 1'b1
    } pl_state_e;

    // Write and read address codes
    localparam logic       WA_CTRL  = 1'b0;
    localparam logic       WA_MODE  = 1'b1;
    localparam logic [1:0] RA_MODE  = 2'd0;
    localparam logic [1:0] RA_STAT  = 2'd1;
    localparam logic [1:0] RA_COUNT = 2'd2;
    localparam logic [1:0] RA_LOCK  = 2'd3;

endpackage

// File: rtl/wdog_presc.sv
// Divides the slow clock into a single-cycle counting tick.
module wdog_presc #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] pre_q;

    assign tick_o = run_i && (pre_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (clr_i) begin
            pre_q <= '0;
        end else if (run_i) begin
            pre_q <= (pre_q == LAST) ? '0 : pre_q + 1'b1;
        end
    end
endmodule

// File: rtl/wdog_mode_lock.sv
// Mode word that accepts its first write after reset and then locks.
module wdog_mode_lock
    import wdog_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_i,
    input  logic [31:0] data_i,
    output wdog_mode_t  mode_o,
    output logic        locked_o
);
    wdog_mode_t incoming;

    always_comb begin
        incoming      = wdog_mode_t'(data_i);
        incoming.rsvd = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_o   <= MODE_DEFAULT;
            locked_o <= 1'b0;
        end else if (wr_i && !locked_o) begin
            mode_o   <= incoming;
            locked_o <= 1'b1;
        end
    end
endmodule

// File: rtl/wdog_downcnt.sv
// Countdown register with load priority and an underflow strobe.
module wdog_downcnt #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         tick_i,
    output logic [W-1:0] cnt_o,
    output logic         uf_o
);
    logic at_zero;

    assign at_zero = (cnt_o == '0);
    assign uf_o    = tick_i && at_zero && !load_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_o <= '1;
        end else if (load_i || uf_o) begin
            cnt_o <= load_val_i;
        end else if (tick_i) begin
            cnt_o <= cnt_o - 1'b1;
        end
    end
endmodule

// File: rtl/wdog_pulse.sv
// Stretches a reset event into a fixed-length pulse; a new event restarts it.
module wdog_pulse
    import wdog_pkg::*;
#(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    output logic drive_o
);
    localparam int CW = (LEN > 1) ? $clog2(LEN) : 1;
    localparam logic [CW-1:0] FIRST = CW'(LEN - 1);

    pl_state_e     ps_q;
    logic [CW-1:0] left_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ps_q   <= PL_IDLE;
            left_q <= '0;
        end else begin
            unique case (ps_q)
                PL_IDLE: begin
                    if (fire_i) begin
                        ps_q   <= PL_DRIVE;
                        left_q <= FIRST;
                    end
                end
                PL_DRIVE: begin
                    if (fire_i) begin
                        left_q <= FIRST;
                    end else if (left_q == '0) begin
                        ps_q <= PL_IDLE;
                    end else begin
                        left_q <= left_q - 1'b1;
                    end
                end
                default: ps_q <= PL_IDLE;
            endcase
        end
    end

    always_comb begin
        drive_o = (ps_q == PL_DRIVE);
    end
endmodule

// File: rtl/wdog_lockwin.sv
// Watchdog top: supervision state machine, keyed restart, window check,
// status flags and register read path.
module wdog_lockwin
    import wdog_pkg::*;
#(
    parameter int PRESCALE  = 128,
    parameter int PULSE_LEN = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        dbg_halt_i,
    input  logic        wr_en_i,
    input  logic        wr_addr_i,
    input  logic [31:0] wr_data_i,
    input  logic        rd_en_i,
    input  logic [1:0]  rd_addr_i,
    output logic [31:0] rd_data_o,
    output logic        sys_rst_req_o,
    output logic        cpu_rst_req_o,
    output logic        uf_flag_o,
    output logic        win_err_o
);
    wdog_mode_t       mode_q;
    logic             locked;
    wd_state_e        st_q, st_d;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;
    logic             uf_evt;
    logic             drive;

    // Register decode
    logic             mode_take;
    logic             ctrl_keyed;
    logic             restart_req;
    logic             in_window;
    logic             restart_ok;
    logic             win_bad;
    logic             cnt_load;
    logic [CNT_W-1:0] cnt_load_val;
    logic             fire;
    logic             freeze_req;
    logic             cnt_run;

    assign mode_take   = wr_en_i && (wr_addr_i == WA_MODE) && !locked;
    assign ctrl_keyed  = wr_en_i && (wr_addr_i == WA_CTRL)
                      && (wr_data_i[31:24] == RESTART_KEY) && wr_data_i[0];
    assign restart_req = ctrl_keyed && (st_q != WD_OFF) && !mode_q.off;
    assign in_window   = (cnt_q <= mode_q.window);
    assign restart_ok  = restart_req && in_window;
    assign win_bad     = restart_req && !in_window;

    assign cnt_load     = mode_take || restart_ok;
    assign cnt_load_val = mode_take ? wr_data_i[CNT_W-1:0] : mode_q.reload;

    assign freeze_req = mode_q.halt_dbg && dbg_halt_i;
    assign cnt_run    = (st_q == WD_ACTIVE);
    assign fire       = (uf_evt || win_bad) && mode_q.rst_en;

    wdog_mode_lock u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_i     (wr_en_i && (wr_addr_i == WA_MODE)),
        .data_i   (wr_data_i),
        .mode_o   (mode_q),
        .locked_o (locked)
    );

    wdog_presc #(.DIV(PRESCALE)) u_presc (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (cnt_run),
        .clr_i  (cnt_load),
        .tick_o (tick)
    );

    wdog_downcnt #(.W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (cnt_load),
        .load_val_i (cnt_load_val),
        .tick_i     (tick),
        .cnt_o      (cnt_q),
        .uf_o       (uf_evt)
    );

    wdog_pulse #(.LEN(PULSE_LEN)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .drive_o (drive)
    );

    // Supervision state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= WD_ACTIVE;
        end else begin
            st_q <= st_d;
        end
    end

    // Supervision transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            WD_ACTIVE: begin
                if (mode_q.off)      st_d = WD_OFF;
                else if (freeze_req) st_d = WD_FROZEN;
            end
            WD_FROZEN: begin
                if (mode_q.off)       st_d = WD_OFF;
                else if (!freeze_req) st_d = WD_ACTIVE;
            end
            WD_OFF: begin
                st_d = WD_OFF;
            end
            default: st_d = WD_ACTIVE;
        endcase
    end

    // Reset routing outputs
    always_comb begin
        sys_rst_req_o = drive && !mode_q.cpu_only;
        cpu_rst_req_o = drive &&  mode_q.cpu_only;
    end

    // Sticky flags; a new event wins over a clearing read
    logic stat_rd;
    assign stat_rd = rd_en_i && (rd_addr_i == RA_STAT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            uf_flag_o <= 1'b0;
            win_err_o <= 1'b0;
        end else begin
            if (uf_evt)       uf_flag_o <= 1'b1;
            else if (stat_rd) uf_flag_o <= 1'b0;
            if (win_bad)      win_err_o <= 1'b1;
            else if (stat_rd) win_err_o <= 1'b0;
        end
    end

    // Registered read path
    logic [31:0] rd_mux;

    always_comb begin
        unique case (rd_addr_i)
            RA_MODE:  rd_mux = mode_q;
            RA_STAT:  rd_mux = {30'b0, win_err_o, uf_flag_o};
            RA_COUNT: rd_mux = {{(32-CNT_W){1'b0}}, cnt_q};
            RA_LOCK:  rd_mux = {31'b0, locked};
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_en_i) begin
            rd_data_o <= rd_mux;
        end
    end
endmodule

// File: rtl/wdog_lockwin_chk.sv
// Property checker bound to the watchdog top.
module wdog_lockwin_chk
    import wdog_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic             wr_addr,
    input logic [31:0]      wr_data,
    input wdog_mode_t       mode,
    input logic             locked,
    input logic [CNT_W-1:0] cnt,
    input wd_state_e        st,
    input logic             sys,
    input logic             cpu,
    input logic             uf_evt,
    input logic             uf_flag
);
    logic keyed;
    assign keyed = wr_en && (wr_addr == WA_CTRL)
                && (wr_data[31:24] == RESTART_KEY) && wr_data[0]
                && (st != WD_OFF) && !mode.off;

    assert_mode_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable(mode));

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= mode.reload);

    assert_restart_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (keyed && (cnt <= mode.window)) |=> (cnt == $past(mode.reload)));

    assert_early_resets_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (keyed && (cnt > mode.window) && mode.rst_en) |=> (sys || cpu));

    assert_uf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> uf_flag);

    assert_outputs_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(sys && cpu));

    assert_pulse_min_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys) |=> sys);

    assert_off_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st == WD_OFF) |=> $stable(cnt));
endmodule

bind wdog_lockwin wdog_lockwin_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .mode    (mode_q),
    .locked  (locked),
    .cnt     (cnt_q),
    .st      (st_q),
    .sys     (sys_rst_req_o),
    .cpu     (cpu_rst_req_o),
    .uf_evt  (uf_evt),
    .uf_flag (uf_flag_o)
);

// File: tb/tb_wdog_lockwin.sv
module tb_wdog_lockwin;
    localparam int PS = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbg_halt_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        wr_addr_i = 1'b0;
    logic [31:0] wr_data_i = '0;
    logic        rd_en_i = 1'b0;
    logic [1:0]  rd_addr_i = '0;
    logic [31:0] rd_data_o;
    logic        sys_rst_req_o, cpu_rst_req_o, uf_flag_o, win_err_o;

    always #5 clk = ~clk;

    wdog_lockwin #(.PRESCALE(PS), .PULSE_LEN(4)) dut (
        .clk(clk), .rst_n(rst_n), .dbg_halt_i(dbg_halt_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_en_i(rd_en_i), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o),
        .sys_rst_req_o(sys_rst_req_o), .cpu_rst_req_o(cpu_rst_req_o),
        .uf_flag_o(uf_flag_o), .win_err_o(win_err_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [31:0] val;
        string       req;
    } item_t;
    item_t exp_q[$];
    item_t mon_it;
    logic  rsp_pend = 1'b0;

    function automatic logic [31:0] mw(input logic [11:0] rl, input logic [11:0] dl,
                                       input logic re, input logic cp,
                                       input logic of, input logic hd);
        return {4'b0, dl, hd, of, cp, re, rl};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Driver tasks: called at a falling edge, return one falling edge later
    task automatic wr(input logic a, input logic [31:0] d);
        wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0; wr_data_i = '0;
    endtask

    task automatic rd(input logic [1:0] a, input logic [31:0] e, input string req);
        item_t it;
        it.val = e; it.req = req;
        exp_q.push_back(it);
        rd_en_i = 1'b1; rd_addr_i = a;
        @(negedge clk);
        rd_en_i = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; dbg_halt_i = 1'b0; wr_en_i = 1'b0; rd_en_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Monitor: compare each read response against the scoreboard
    always @(posedge clk) rsp_pend <= rd_en_i;

    always @(negedge clk) begin
        if (rsp_pend) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_bad++;
                $display("FAIL scoreboard: actual %h expected none", rd_data_o);
            end else begin
                mon_it = exp_q.pop_front();
                if (rd_data_o !== mon_it.val) begin
                    n_bad++;
                    $display("FAIL %s: read actual %h expected %h", mon_it.req, rd_data_o, mon_it.val);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // ---- R1: reset state
        do_reset();
        rd(2'd2, 32'h0000_0FFF, "R1");
        rd(2'd0, 32'h0FFF_1FFF, "R1");
        rd(2'd1, 32'h0, "R1");
        rd(2'd3, 32'h0, "R1");
        chk("R1", {30'b0, sys_rst_req_o, cpu_rst_req_o}, 32'h0);

        // ---- R6/R7: underflow timing, system reset pulse
        wr(1'b1, mw(12'd5, 12'hFFF, 1'b1, 1'b0, 1'b0, 1'b0));
        repeat (4*6-1) @(negedge clk);
        chk("R7", {31'b0, sys_rst_req_o}, 32'h0);
        @(negedge clk);
        chk("R7", {30'b0, sys_rst_req_o, cpu_rst_req_o}, 32'h2);
        chk("R6", {31'b0, uf_flag_o}, 32'h1);
        repeat (3) @(negedge clk);
        chk("R7", {31'b0, sys_rst_req_o}, 32'h1);
        @(negedge clk);
        chk("R7", {31'b0, sys_rst_req_o}, 32'h0);
        rd(2'd1, 32'h1, "R6");
        rd(2'd1, 32'h0, "R6");

        // ---- R2: second mode write ignored
        wr(1'b1, mw(12'd9, 12'h003, 1'b0, 1'b1, 1'b0, 1'b1));
        rd(2'd0, mw(12'd5, 12'hFFF, 1'b1, 1'b0, 1'b0, 1'b0), "R2");
        rd(2'd3, 32'h1, "R2");

        // ---- R3/R4: restart reload, tick rate, bad keys
        wr(1'b0, 32'hA500_0001);
        rd(2'd2, 32'd5, "R4");
        repeat (3) @(negedge clk);
        rd(2'd2, 32'd4, "R3");
        wr(1'b0, 32'h5A00_0001);
        wr(1'b0, 32'hA500_0000);
        rd(2'd2, 32'd4, "R4");

        // ---- R7: processor-only routing
        do_reset();
        wr(1'b1, mw(12'd3, 12'hFFF, 1'b1, 1'b1, 1'b0, 1'b0));
        repeat (4*4-1) @(negedge clk);
        chk("R7", {31'b0, cpu_rst_req_o}, 32'h0);
        @(negedge clk);
        chk("R7", {30'b0, sys_rst_req_o, cpu_rst_req_o}, 32'h1);
        repeat (3) @(negedge clk);
        chk("R7", {31'b0, cpu_rst_req_o}, 32'h1);
        @(negedge clk);
        chk("R7", {31'b0, cpu_rst_req_o}, 32'h0);

        // ---- R7: reset enable clear suppresses both outputs
        do_reset();
        wr(1'b1, mw(12'd3, 12'hFFF, 1'b0, 1'b0, 1'b0, 1'b0));
        repeat (4*4-1) @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            chk("R7", {30'b0, sys_rst_req_o, cpu_rst_req_o}, 32'h0);
        end
        chk("R6", {31'b0, uf_flag_o}, 32'h1);

        // ---- R5: early restart refused, in-window restart accepted
        do_reset();
        wr(1'b1, mw(12'd20, 12'd5, 1'b1, 1'b0, 1'b0, 1'b0));
        wr(1'b0, 32'h3C00_0001);
        chk("R4", {30'b0, sys_rst_req_o, win_err_o}, 32'h0);
        wr(1'b0, 32'hA500_0001);
        chk("R5", {30'b0, sys_rst_req_o, win_err_o}, 32'h3);
        rd(2'd1, 32'h2, "R5");
        repeat (62) @(negedge clk);
        wr(1'b0, 32'hA500_0001);
        rd(2'd2, 32'd20, "R5");
        rd(2'd1, 32'h0, "R5");

        // ---- R8: disabled block
        do_reset();
        wr(1'b1, mw(12'd2, 12'd0, 1'b1, 1'b0, 1'b1, 1'b0));
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (sys_rst_req_o || cpu_rst_req_o)
                chk("R8", {30'b0, sys_rst_req_o, cpu_rst_req_o}, 32'h0);
        end
        chk("R8", {30'b0, sys_rst_req_o, cpu_rst_req_o}, 32'h0);
        wr(1'b0, 32'hA500_0001);
        chk("R8", {31'b0, win_err_o}, 32'h0);
        rd(2'd2, 32'd2, "R8");
        rd(2'd1, 32'h0, "R8");

        // ---- R9: debug halt enabled freezes
        do_reset();
        wr(1'b1, mw(12'd10, 12'hFFF, 1'b1, 1'b0, 1'b0, 1'b1));
        dbg_halt_i = 1'b1;
        repeat (20) @(negedge clk);
        rd(2'd2, 32'd10, "R9");
        repeat (60) @(negedge clk);
        chk("R9", {30'b0, sys_rst_req_o, uf_flag_o}, 32'h0);
        dbg_halt_i = 1'b0;

        // ---- R9: debug input ignored when halt option clear
        do_reset();
        wr(1'b1, mw(12'd10, 12'hFFF, 1'b1, 1'b0, 1'b0, 1'b0));
        dbg_halt_i = 1'b1;
        repeat (20) @(negedge clk);
        rd(2'd2, 32'd5, "R9");
        dbg_halt_i = 1'b0;

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) chk("scoreboard", exp_q.size(), 0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule